// File: doc/BRIEF.md
# Time-of-Day Aligned Pulse Train Generator

This block produces up to three periodic pulse trains whose edges are tied to a free-running nanosecond time value supplied from outside. Each train is a down-counter loaded from its own interval register. On every clock cycle it subtracts the nominal clock period, in nanoseconds. When the remaining count is smaller than one period, the train emits a one-cycle event strobe and starts a pulse on its output line. The pulse lasts a programmable number of clock cycles (the prescale value). It then reloads and counts down again.

The trains do not have to run freely. Two 64-bit alarm comparators watch the time input. The first alarm can start all trains, or pull them back into phase, at a time the host has chosen. Software typically picks a whole-second boundary minus one nominal period. An interval of prescale × period × divider − period then gives one event per second, on the second. Each alarm also drives an output line with selectable polarity. The first two trains can be looped back onto trigger lines that feed an external timestamp unit.

Configuration arrives as single-cycle register writes. The interval and prescale registers are frozen while the timer is enabled. To reprogram them, software disables the timer, rewrites the values and the alarm, and then enables the timer again.

Top module: `tod_pulse_gen`

## Requirements
- R1: After reset every pulse line, event strobe, alarm strobe, alarm line and loopback line is low.
- R2: Writing the high word of alarm a (address 3+2a; the low word is at address 2+2a) arms that alarm. While the enable bit (control bit 2, control register at address 0) is set and the alarm is armed, its strobe rises for exactly one cycle. This happens in the cycle after the first cycle in which the time input is greater than or equal to the alarm value. The alarm then disarms, so it fires once per arming even when the time input steps over the exact value.
- R3: Control bit 31 sets the polarity of alarm line 0 and bit 30 that of alarm line 1. When the bit is 0 the line equals the strobe. When the bit is 1 the line idles high and is low during the strobe cycle.
- R4: When control bits 2 and 28 are both set, the trains stay idle until alarm 0 strobes. Train g then gives its first event strobe k+1 cycles after the alarm strobe cycle.
- R5: Interval register g sits at address 6+g and holds a value I in nanoseconds. With period p, a running train gives an event every floor(I/p)+1 cycles. This is the k used in R4, R7 and R8.
- R6: Each pulse line rises together with its event strobe. It stays high for the prescale value in cycles (prescale register at address 1, low 16 bits; a value of 0 acts as 1).
- R7: When bit 2 is set and bit 28 is clear, each train starts on its own. Its first event comes k+1 cycles after the first cycle in which the enable is visible.
- R8: If alarm 0 strobes while a train is running and control bit 14 is clear, the train restarts its count. Its next event comes k+1 cycles after the strobe cycle.
- R9: With control bit 14 set, an alarm 0 strobe leaves running trains on their existing schedule.
- R10: Alarm 1 never starts or realigns a train.
- R11: Clearing bit 2 stops every train. From the second cycle after the write, all pulse lines and event strobes stay low.
- R12: Writes to the interval and prescale registers are ignored while bit 2 is set.
- R13: Control bit 27 copies pulse line 0 onto loopback line 0, and bit 26 copies pulse line 1 onto loopback line 1. When the bit is clear, the loopback line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Current time of day in nanoseconds |
| period_i | input | 10 | Nominal clock period in nanoseconds |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| pulse_o | output | 3 | Pulse line per train |
| evt_o | output | 3 | One-cycle event strobe per train |
| alarm_o | output | 2 | Alarm lines after polarity |
| alarm_evt_o | output | 2 | One-cycle alarm strobes |
| trig_loop_o | output | 2 | Loopback of pulse lines 0 and 1 |

## Verification
Writes take effect in the cycle after the write cycle. An alarm strobe is due one cycle after the first cycle in which the time input reaches the alarm value. The first train event is due k+1 cycles after that strobe. In free-running mode it is due k+1 cycles after enable becomes visible. A disable silences all outputs from the second cycle after the write. The bench keeps an absolute cycle counter and computes the time input from it. For every case it works out the exact cycle each strobe is due, records the cycles in which strobes appear, and compares the two. Outputs are sampled two time units after each rising edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int DATA_W  = 32;
    localparam int N_ALARM = 2;

    // register addresses
    localparam int A_CTRL     = 0;
    localparam int A_PRSC     = 1;
    localparam int A_ALM_BASE = 2;                        // lo at base+2a, hi at base+2a+1
    localparam int A_IVL_BASE = A_ALM_BASE + 2 * N_ALARM; // interval g at base+g

    // control bit positions
    localparam int CB_EN      = 2;
    localparam int CB_NOALIGN = 14;
    localparam int CB_LOOP1   = 26;
    localparam int CB_LOOP0   = 27;
    localparam int CB_START   = 28;
    localparam int CB_POL1    = 30;
    localparam int CB_POL0    = 31;

    typedef struct packed {
        logic       en;
        logic       start_on_alarm;
        logic       no_realign;
        logic [1:0] loop;
        logic [1:0] pol;
    } ctrl_t;

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int N_GEN  = 3,
    parameter int ADDR_W = 4,
    parameter int PRSC_W = 16,
    parameter int TIME_W = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [ADDR_W-1:0]                  wr_addr_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    output ctrl_t                              ctrl_o,
    output logic [PRSC_W-1:0]                  prsc_o,
    output logic [N_ALARM-1:0][TIME_W-1:0]     alarm_o,
    output logic [N_ALARM-1:0]                 arm_o,
    output logic [N_GEN-1:0][DATA_W-1:0]       ivl_o
);

    localparam int HI_W = TIME_W - DATA_W;

    typedef struct packed {
        ctrl_t                           ctrl;
        logic [PRSC_W-1:0]               prsc;
        logic [N_ALARM-1:0][TIME_W-1:0]  alm;
        logic [N_GEN-1:0][DATA_W-1:0]    ivl;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic [N_ALARM-1:0] arm_d;
    logic               frozen;

    always_comb begin
        s_d    = s_q;
        arm_d  = '0;
        frozen = s_q.ctrl.en;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(A_CTRL)) begin
                s_d.ctrl.en             = wr_data_i[CB_EN];
                s_d.ctrl.start_on_alarm = wr_data_i[CB_START];
                s_d.ctrl.no_realign     = wr_data_i[CB_NOALIGN];
                s_d.ctrl.loop           = {wr_data_i[CB_LOOP1], wr_data_i[CB_LOOP0]};
                s_d.ctrl.pol            = {wr_data_i[CB_POL1], wr_data_i[CB_POL0]};
            end
            if (wr_addr_i == ADDR_W'(A_PRSC) && !frozen) begin
                s_d.prsc = wr_data_i[PRSC_W-1:0];
            end
            for (int a = 0; a < N_ALARM; a++) begin
                if (wr_addr_i == ADDR_W'(A_ALM_BASE + 2 * a)) begin
                    s_d.alm[a][DATA_W-1:0] = wr_data_i;
                end
                if (wr_addr_i == ADDR_W'(A_ALM_BASE + 2 * a + 1)) begin
                    s_d.alm[a][TIME_W-1:DATA_W] = wr_data_i[HI_W-1:0];
                    arm_d[a] = 1'b1;
                end
            end
            for (int g = 0; g < N_GEN; g++) begin
                if (wr_addr_i == ADDR_W'(A_IVL_BASE + g) && !frozen) begin
                    s_d.ivl[g] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o  = s_q.ctrl;
    assign prsc_o  = s_q.prsc;
    assign alarm_o = s_q.alm;
    assign ivl_o   = s_q.ivl;
    assign arm_o   = arm_d;

endmodule

// File: rtl/tpg_alarm.sv
module tpg_alarm #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              arm_i,
    input  logic              pol_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] value_i,
    output logic              evt_o,
    output logic              line_o
);

    typedef struct packed {
        logic armed;
        logic fire;
    } alm_state_t;

    alm_state_t s_d, s_q;
    logic       reached;

    always_comb begin
        reached   = time_i >= value_i;
        s_d.fire  = s_q.armed & en_i & reached;
        s_d.armed = arm_i | (s_q.armed & ~s_d.fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt_o  = s_q.fire;
    assign line_o = s_q.fire ^ pol_i;

endmodule

// File: rtl/tpg_interval.sv
module tpg_interval #(
    parameter int CNT_W    = 32,
    parameter int PRSC_W   = 16,
    parameter int PERIOD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                wait_align_i,
    input  logic                no_realign_i,
    input  logic                align_i,
    input  logic [CNT_W-1:0]    ivl_i,
    input  logic [PRSC_W-1:0]   prsc_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                evt_o,
    output logic                pulse_o
);

    typedef struct packed {
        logic              run;
        logic [CNT_W-1:0]  cnt;
        logic [PRSC_W-1:0] wid;
        logic              evt;
    } gen_state_t;

    gen_state_t        s_d, s_q;
    logic [CNT_W-1:0]  step;
    logic [PRSC_W-1:0] wid_load;
    logic              expire;
    logic              launch;

    always_comb begin
        s_d      = s_q;
        s_d.evt  = 1'b0;
        step     = CNT_W'(period_i);
        expire   = s_q.cnt < step;
        wid_load = (prsc_i == '0) ? PRSC_W'(1) : prsc_i;
        launch   = align_i ? (!s_q.run || !no_realign_i)
                           : (!wait_align_i && !s_q.run);
        if (!en_i) begin
            s_d = '0;
        end else if (launch) begin
            s_d.run = 1'b1;
            s_d.cnt = ivl_i;
            s_d.wid = '0;
        end else if (s_q.run) begin
            if (s_q.wid != '0) s_d.wid = s_q.wid - PRSC_W'(1);
            if (expire) begin
                s_d.evt = 1'b1;
                s_d.cnt = ivl_i;
                s_d.wid = wid_load;
            end else begin
                s_d.cnt = s_q.cnt - step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt_o   = s_q.evt;
    assign pulse_o = s_q.wid != '0;

endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
    import tpg_pkg::*;
#(
    parameter int N_GEN    = 3,
    parameter int ADDR_W   = 4,
    parameter int TIME_W   = 64,
    parameter int PRSC_W   = 16,
    parameter int PERIOD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIME_W-1:0]   time_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [N_GEN-1:0]    pulse_o,
    output logic [N_GEN-1:0]    evt_o,
    output logic [N_ALARM-1:0]  alarm_o,
    output logic [N_ALARM-1:0]  alarm_evt_o,
    output logic [1:0]          trig_loop_o
);

    ctrl_t                          ctrl;
    logic [PRSC_W-1:0]              prsc;
    logic [N_ALARM-1:0][TIME_W-1:0] alm_val;
    logic [N_ALARM-1:0]             alm_arm;
    logic [N_GEN-1:0][DATA_W-1:0]   ivl;
    logic                           tmr_en;

    assign tmr_en = ctrl.en;

    tpg_regs #(
        .N_GEN  (N_GEN),
        .ADDR_W (ADDR_W),
        .PRSC_W (PRSC_W),
        .TIME_W (TIME_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl),
        .prsc_o    (prsc),
        .alarm_o   (alm_val),
        .arm_o     (alm_arm),
        .ivl_o     (ivl)
    );

    for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
        tpg_alarm #(.TIME_W(TIME_W)) u_alarm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (tmr_en),
            .arm_i   (alm_arm[a]),
            .pol_i   (ctrl.pol[a]),
            .time_i  (time_i),
            .value_i (alm_val[a]),
            .evt_o   (alarm_evt_o[a]),
            .line_o  (alarm_o[a])
        );
    end

    for (genvar g = 0; g < N_GEN; g++) begin : g_train
        tpg_interval #(
            .CNT_W    (DATA_W),
            .PRSC_W   (PRSC_W),
            .PERIOD_W (PERIOD_W)
        ) u_train (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (tmr_en),
            .wait_align_i (ctrl.start_on_alarm),
            .no_realign_i (ctrl.no_realign),
            .align_i      (alarm_evt_o[0]),
            .ivl_i        (ivl[g]),
            .prsc_i       (prsc),
            .period_i     (period_i),
            .evt_o        (evt_o[g]),
            .pulse_o      (pulse_o[g])
        );
    end

    for (genvar i = 0; i < 2; i++) begin : g_loop
        if (i < N_GEN) begin : g_on
            assign trig_loop_o[i] = pulse_o[i] & ctrl.loop[i];
        end else begin : g_off
            assign trig_loop_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/tod_pulse_gen_chk.sv
module tod_pulse_gen_chk #(
    parameter int N_GEN   = 3,
    parameter int N_ALARM = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [N_GEN-1:0]   pulse_o,
    input logic [N_GEN-1:0]   evt_o,
    input logic [N_ALARM-1:0] alarm_evt_o,
    input logic [1:0]         trig_loop_o
);

    for (genvar a = 0; a < N_ALARM; a++) begin : g_a
        // R2: an alarm strobe lasts a single cycle
        p_alarm_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            alarm_evt_o[a] |=> !alarm_evt_o[a]);
    end

    for (genvar g = 0; g < N_GEN; g++) begin : g_g
        // R6: a pulse only begins together with its event strobe
        p_pulse_rise_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_o[g]) |-> evt_o[g]);
    end

    // R11: two disabled cycles in a row leave every train silent
    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (evt_o == '0 && pulse_o == '0));

    // R4: an event strobe requires the timer to have been enabled
    p_evt_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != '0) |-> $past(en));

    for (genvar i = 0; i < 2; i++) begin : g_l
        if (i < N_GEN) begin : g_on
            // R13: a loopback line is never high without its pulse
            p_loop_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
                trig_loop_o[i] |-> pulse_o[i]);
        end
    end

endmodule

bind tod_pulse_gen tod_pulse_gen_chk #(.N_GEN(N_GEN), .N_ALARM(tpg_pkg::N_ALARM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (tmr_en),
    .pulse_o     (pulse_o),
    .evt_o       (evt_o),
    .alarm_evt_o (alarm_evt_o),
    .trig_loop_o (trig_loop_o)
);

// File: tb/tod_pulse_gen_tb.sv
module tod_pulse_gen_tb;

    localparam int CLK_NS = 10;
    localparam int PER_NS = 10;
    localparam logic [31:0] B_EN      = 32'h1 << 2;
    localparam logic [31:0] B_NOALIGN = 32'h1 << 14;
    localparam logic [31:0] B_LOOP1   = 32'h1 << 26;
    localparam logic [31:0] B_LOOP0   = 32'h1 << 27;
    localparam logic [31:0] B_START   = 32'h1 << 28;
    localparam logic [31:0] B_POL1    = 32'h1 << 30;

    typedef struct packed {
        int k0; int k1; int k2; int prsc; int lead; int skip;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{4, 5, 7, 2, 3, 0},
        '{3, 6, 2, 1, 5, 1},
        '{8, 3, 5, 5, 1, 0},
        '{5, 5, 9, 3, 4, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tod = 64'h0000_0001_0000_0000 - 64'd3000;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  pulse, evt;
    logic [1:0]  alarm, alarm_evt, loopb;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int first [3];
    int second [3];
    int acyc [2];
    int acnt [2];
    int aline [2];
    int pw, pulse_any, loop_err, loop_hi;
    bit exp_loop0, exp_loop1;

    tod_pulse_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_i      (tod),
        .period_i    (10'(PER_NS)),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .pulse_o     (pulse),
        .evt_o       (evt),
        .alarm_o     (alarm),
        .alarm_evt_o (alarm_evt),
        .trig_loop_o (loopb)
    );

    initial forever #(CLK_NS / 2) clk = ~clk;

    // time source and cycle counter: both step 1 unit after each edge
    initial forever begin
        @(posedge clk);
        #1;
        cyc = cyc + 1;
        tod = tod + 64'(PER_NS);
    end

    task automatic nxt();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = addr[3:0];
        wr_data = data;
        nxt();
        wr_en   = 1'b0;
    endtask

    task automatic watch(input int ncyc, input int min_cyc);
        for (int g = 0; g < 3; g++) begin first[g] = -1; second[g] = -1; end
        for (int a = 0; a < 2; a++) begin acyc[a] = -1; acnt[a] = 0; aline[a] = -1; end
        pw = 0; pulse_any = 0; loop_err = 0; loop_hi = 0;
        for (int n = 0; n < ncyc; n++) begin
            nxt();
            for (int a = 0; a < 2; a++) begin
                if (alarm_evt[a]) begin
                    acnt[a]++;
                    if (acyc[a] < 0) begin acyc[a] = cyc; aline[a] = int'(alarm[a]); end
                end
            end
            for (int g = 0; g < 3; g++) begin
                if (evt[g] && cyc >= min_cyc) begin
                    if (first[g] < 0) first[g] = cyc;
                    else if (second[g] < 0) second[g] = cyc;
                end
            end
            if (first[0] >= 0 && second[0] < 0 && pulse[0]) pw++;
            if (pulse != 0) pulse_any++;
            if (loopb[0] != (pulse[0] & exp_loop0)) loop_err++;
            if (loopb[1] != (pulse[1] & exp_loop1)) loop_err++;
            if (loopb[0]) loop_hi++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int        m, lead, e_last, expv;
        logic [63:0] av;
        exp_loop0 = 0;
        exp_loop1 = 0;
        repeat (3) nxt();
        // R1: reset state
        check("R1 pulse", int'(pulse), 0);
        check("R1 evt", int'(evt), 0);
        check("R1 alarm line", int'(alarm), 0);
        check("R1 alarm strobe", int'(alarm_evt), 0);
        check("R1 loopback", int'(loopb), 0);
        rst_n = 1'b1;
        nxt();

        // table walk: alarm-started trains (R2 R3 R4 R5 R6)
        foreach (VECS[i]) begin
            int ks [3];
            ks[0] = VECS[i].k0; ks[1] = VECS[i].k1; ks[2] = VECS[i].k2;
            wr(0, 32'h0);
            wr(1, 32'(VECS[i].prsc));
            for (int g = 0; g < 3; g++)
                wr(6 + g, 32'((ks[g] - 1) * PER_NS + (VECS[i].skip != 0 ? 7 : 0)));
            wr(0, B_EN | B_START);
            av = tod + 64'(PER_NS * (2 + VECS[i].lead)) + (VECS[i].skip != 0 ? 64'd5 : 64'd0);
            m  = cyc + 2 + VECS[i].lead + (VECS[i].skip != 0 ? 1 : 0);
            wr(2, av[31:0]);
            wr(3, av[63:32]);
            watch(40, 0);
            check("R2 alarm0 strobe cycle", acyc[0], m + 1);
            check("R2 alarm0 fires once", acnt[0], 1);
            check("R3 alarm0 line active high", aline[0], 1);
            check("R13 loopback off", loop_err, 0);
            for (int g = 0; g < 3; g++) begin
                check("R4 first event after alarm", first[g], m + ks[g] + 2);
                check("R5 event spacing", second[g] - first[g], ks[g]);
            end
            check("R6 pulse width", pw, VECS[i].prsc);
        end

        // R12: interval and prescale writes while enabled are ignored (k0=5, prsc=3)
        wr(6, 32'(2 * PER_NS));
        wr(1, 32'd1);
        watch(20, cyc);
        check("R12 spacing unchanged", second[0] - first[0], 5);
        check("R12 width unchanged", pw, 3);
        e_last = second[0];

        // R8: realign on alarm 0 while running
        lead = 1;
        for (int l = 1; l < 20; l++) begin
            if (((cyc + 4 + l - e_last) % 5) == 2) begin lead = l; break; end
        end
        av = tod + 64'(PER_NS * (2 + lead));
        m  = cyc + 2 + lead;
        wr(2, av[31:0]);
        wr(3, av[63:32]);
        watch(30, m + 2);
        check("R8 realign strobe", acyc[0], m + 1);
        check("R8 realigned event", first[0], m + 7);
        e_last = second[0];

        // R9: realign disabled, schedule kept
        wr(0, B_EN | B_START | B_NOALIGN);
        lead = 1;
        for (int l = 1; l < 20; l++) begin
            if (((cyc + 4 + l - e_last) % 5) == 2) begin lead = l; break; end
        end
        av = tod + 64'(PER_NS * (2 + lead));
        m  = cyc + 2 + lead;
        wr(2, av[31:0]);
        wr(3, av[63:32]);
        watch(30, m + 2);
        expv = e_last;
        while (expv < m + 2) expv += 5;
        check("R9 alarm still strobes", acyc[0], m + 1);
        check("R9 schedule kept", first[0], expv);

        // R10 and R3: alarm 1 with inverted polarity, trains waiting
        wr(0, 32'h0);
        wr(0, B_EN | B_START | B_POL1);
        check("R3 alarm1 idles high", int'(alarm[1]), 1);
        check("R3 alarm0 idles low", int'(alarm[0]), 0);
        av = tod + 64'(PER_NS * 4);
        m  = cyc + 4;
        wr(4, av[31:0]);
        wr(5, av[63:32]);
        watch(20, 0);
        check("R2 alarm1 strobe cycle", acyc[1], m + 1);
        check("R3 alarm1 low on strobe", aline[1], 0);
        check("R10 no start by alarm1", first[0] + first[1] + first[2], -3);

        // R7 and R13: free-running start with loopback 0 on
        wr(0, 32'h0);
        wr(1, 32'd2);
        wr(6, 32'(3 * PER_NS));
        wr(7, 32'(2 * PER_NS));
        exp_loop0 = 1;
        exp_loop1 = 0;
        wr(0, B_EN | B_LOOP0);
        m = cyc;
        watch(25, 0);
        check("R7 free start train0", first[0], m + 5);
        check("R7 free start train1", first[1], m + 4);
        check("R13 loopback follows", loop_err, 0);
        check("R13 loopback seen", int'(loop_hi > 0), 1);

        // R13: loopback 1 only
        exp_loop0 = 0;
        exp_loop1 = 1;
        wr(0, B_EN | B_LOOP1);
        watch(15, 0);
        check("R13 loopback1 follows", loop_err, 0);

        // R11: disable stops everything
        exp_loop1 = 0;
        wr(0, 32'h0);
        watch(20, 0);
        check("R11 no events", first[0] + first[1] + first[2], -3);
        check("R11 pulses low", pulse_any, 0);

        finish_run();
    end

endmodule